// File: doc/BRIEF.md
# Prescaled Eight-Bit Timer/Counter

This block is an 8-bit up-counter for general timing and event counting. It counts either an internal instruction-cycle tick, produced by dividing the system clock by four, or transitions on one of two external inputs: a dedicated clock pin or an oscillator signal. For both external inputs, software picks whether rising or falling transitions count. Each external input passes through a two-stage synchronizer that advances on the instruction tick. An edge detector follows it, so every qualifying transition is counted exactly once.

An optional 8-bit prescaler divides the selected event stream by a power of two, from 2 up to 256, or can be bypassed. Software loads the count through a write port. A load also clears the prescaler and holds off counting for the next two instruction ticks. When the count wraps from 0xFF to 0x00, the block sets a sticky interrupt flag. It also drives a single-clock overflow pulse that a downstream timer can use as a gate or a clock.

Top module: `tick_counter8`

## Requirements
- R1: After reset the count reads 0x00, the interrupt flag and the overflow pulse are low, and the configuration selects the internal tick with the prescaler bypassed.
- R2: In internal mode (config bit 6 = 0) with the prescaler bypassed, the count advances by one every four system clocks.
- R3: A count write loads the written value on the next clock edge. The next two instruction ticks after the write produce no increment and no prescaler event.
- R4: Config bits [2:0] form a ratio field f. With config bit 3 = 0, the count advances once per 2^(f+1) source events. With config bit 3 = 1, the count advances on every source event and the ratio field has no effect.
- R5: A count write clears the prescaler's partial count.
- R6: When an increment takes the count from 0xFF to 0x00, the overflow output goes high for exactly one system clock and the interrupt flag becomes set. The flag stays set afterwards.
- R7: While no overflow happens, asserting the clear input clears the flag on the next edge. If an overflow happens on the same edge as a clear, the flag is set.
- R8: In external mode (config bit 6 = 1), config bit 4 = 0 counts rising transitions of the selected input and config bit 4 = 1 counts falling transitions.
- R9: Config bit 5 = 0 selects the clock pin and config bit 5 = 1 selects the oscillator input. Transitions on the input that is not selected leave the count unchanged.
- R10: An external transition takes at least two instruction ticks to affect the count. A level held for any length of time yields exactly one count for the transition that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Count load strobe |
| cnt_wr_data | input | 8 | Value loaded into the count |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 7 | Configuration: [6] external mode, [5] oscillator select, [4] falling edge, [3] prescaler bypass, [2:0] ratio |
| clk_pin | input | 1 | External clock pin |
| osc_in | input | 1 | External oscillator signal |
| irq_clr | input | 1 | Clears the interrupt flag |
| count_q | output | 8 | Current count |
| irq_flag | output | 1 | Sticky overflow interrupt flag |
| ovf_pulse | output | 1 | One-clock overflow pulse for a downstream timer |

## Verification
Some properties are checked on every cycle. The instruction tick is never high on two adjacent clocks. The count changes only on a tick or on a load, and a load always lands. The overflow pulse lasts a single clock and is always paired with a set flag. A clear without a coincident overflow always empties the flag. Other behaviour can only be shown by the bench's scenarios. These are the prescaler ratios, the two-tick hold-off after a load, the prescaler reset on a load, edge polarity, source selection with an ignored input, and synchronizer latency, each checked against counts computed from the number of elapsed ticks and applied transitions.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
    localparam int PS_W    = 8;
    localparam int RATIO_W = $clog2(PS_W);
    localparam int CFG_W   = RATIO_W + 4;

    typedef struct packed {
        logic               ext_mode;
        logic               osc_sel;
        logic               fall_edge;
        logic               pre_bypass;
        logic [RATIO_W-1:0] ratio;
    } tc8_cfg_t;

    localparam tc8_cfg_t CFG_RST = '{ext_mode: 1'b0, osc_sel: 1'b0,
                                     fall_edge: 1'b0, pre_bypass: 1'b1,
                                     ratio: '0};

    typedef enum logic [1:0] {SRC_TICK, SRC_PIN, SRC_OSC} tc8_src_e;

    function automatic tc8_src_e pick_src(tc8_cfg_t c);
        if (!c.ext_mode)    return SRC_TICK;
        else if (c.osc_sel) return SRC_OSC;
        else                return SRC_PIN;
    endfunction

    // low (r+1) bits set: terminal pattern for a divide by 2^(r+1)
    function automatic logic [PS_W-1:0] ratio_mask(logic [RATIO_W-1:0] r);
        logic [PS_W-1:0] m;
        for (int i = 0; i < PS_W; i++) m[i] = (i <= int'(r));
        return m;
    endfunction
endpackage

// File: rtl/tc8_tick_gen.sv
module tc8_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                 phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                     phase <= phase + PH_W'(1);
    end

    assign tick = (phase == PH_LAST);

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tc8_edge_sync.sv
module tc8_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic din,
    input  logic fall_sel,
    output logic edge_hit
);
    logic [STAGES-1:0] sh;
    logic              prev;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else if (adv) begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    assign cur      = sh[STAGES-1];
    assign edge_hit = fall_sel ? (prev & ~cur) : (~prev & cur);
endmodule

// File: rtl/tc8_prescaler.sv
module tc8_prescaler
    import tc8_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               evt_in,
    input  logic               bypass,
    input  logic [RATIO_W-1:0] ratio,
    output logic               evt_out
);
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] mask;
    logic            terminal;

    assign mask     = ratio_mask(ratio);
    assign terminal = ((pcnt & mask) == mask);
    assign evt_out  = bypass ? evt_in : (evt_in & terminal);

    always_ff @(posedge clk) begin
        if (rst || clr)             pcnt <= '0;
        else if (evt_in && !bypass) pcnt <= pcnt + PS_W'(1);
    end
endmodule

// File: rtl/tick_counter8.sv
module tick_counter8
    import tc8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             clk_pin,
    input  logic             osc_in,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_flag,
    output logic             ovf_pulse
);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
    localparam int N_EXT  = 2;

    tc8_cfg_t        cfg;
    tc8_src_e        src;
    logic            tick;
    logic [N_EXT-1:0] ext_vec;
    logic [N_EXT-1:0] ext_hit;
    logic            src_evt;
    logic            gated_evt;
    logic            inc;
    logic            wrap;
    logic [HOLD_W-1:0] hold;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cfg <= CFG_RST;
        else if (cfg_wr_en) cfg <= tc8_cfg_t'(cfg_wr_data);
    end

    assign src = pick_src(cfg);

    tc8_tick_gen #(.DIV(DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    assign ext_vec = {osc_in, clk_pin};

    for (genvar g = 0; g < N_EXT; g++) begin : g_sync
        tc8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .adv     (tick),
            .din     (ext_vec[g]),
            .fall_sel(cfg.fall_edge),
            .edge_hit(ext_hit[g])
        );
    end

    always_comb begin
        unique case (src)
            SRC_PIN: src_evt = tick & ext_hit[0];
            SRC_OSC: src_evt = tick & ext_hit[1];
            default: src_evt = tick;
        endcase
    end

    // hold-off after a count load, measured in instruction ticks
    always_ff @(posedge clk) begin
        if (rst)                     hold <= '0;
        else if (cnt_wr_en)          hold <= HOLD_W'(HOLD_TICKS);
        else if (tick && hold != '0) hold <= hold - HOLD_W'(1);
    end

    assign gated_evt = src_evt & (hold == '0) & ~cnt_wr_en;

    tc8_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_wr_en),
        .evt_in (gated_evt),
        .bypass (cfg.pre_bypass),
        .ratio  (cfg.ratio),
        .evt_out(inc)
    );

    assign wrap = inc & (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (cnt_wr_en) cnt <= cnt_wr_data;
        else if (inc)       cnt <= cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            ovf_pulse <= wrap;
            if (wrap)         irq_flag <= 1'b1;
            else if (irq_clr) irq_flag <= 1'b0;
        end
    end

    assign count_q = cnt;

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_wr_en) |-> (count_q == $past(cnt_wr_data)));

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(cnt_wr_en) && !$past(tick)) |-> $stable(count_q));

    p_ovf_width_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

    p_ovf_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> irq_flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_clr) && !ovf_pulse) |-> !irq_flag);
endmodule

// File: tb/tick_counter8_tb_top.sv
module tick_counter8_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = '0;
    logic       cfg_wr_en = 1'b0;
    logic [6:0] cfg_wr_data = '0;
    logic       clk_pin = 1'b0;
    logic       osc_in = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] count_q;
    logic       irq_flag;
    logic       ovf_pulse;

    always #4 clk = ~clk;

    tick_counter8 dut_i (
        .clk(clk), .rst(rst),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .clk_pin(clk_pin), .osc_in(osc_in), .irq_clr(irq_clr),
        .count_q(count_q), .irq_flag(irq_flag), .ovf_pulse(ovf_pulse)
    );

    typedef enum int {K_COUNT, K_FLAG, K_OVF_SEEN, K_FLAG_AT_OVF} kind_e;
    typedef struct {
        kind_e kind;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    int    ovf_seen = 0;
    int    flag_at_ovf = 0;
    bit    done = 0;

    always @(negedge clk) begin
        if (!rst && ovf_pulse) begin
            ovf_seen++;
            flag_at_ovf = irq_flag;
        end
    end

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            int act;
            item_t it;
            wait (q.size() > 0);
            #1;
            it = q.pop_front();
            case (it.kind)
                K_COUNT:       act = int'(count_q);
                K_FLAG:        act = int'(irq_flag);
                K_OVF_SEEN:    act = ovf_seen;
                default:       act = flag_at_ovf;
            endcase
            n_tests++;
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%0d expected=%0d",
                         it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(kind_e k, int v, string req);
        item_t it;
        it.kind = k; it.exp = v; it.req = req;
        q.push_back(it);
        wait (q.size() == 0);
        #1;
    endtask

    function automatic logic [6:0] mk_cfg(bit ext, bit osc, bit fall, bit byp, int r);
        return {ext, osc, fall, byp, 3'(r)};
    endfunction

    task automatic wr_cfg(logic [6:0] v);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    // ends at the negedge right after the load edge
    task automatic wr_cnt(logic [7:0] v);
        @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = v;
        @(negedge clk); cnt_wr_en = 1'b0;
    endtask

    task automatic wait_ticks(int m);
        repeat (4 * m) @(negedge clk);
    endtask

    task automatic toggle_run(bit use_osc, int n);
        for (int i = 0; i < n; i++) begin
            if (use_osc) osc_in = 1'b1; else clk_pin = 1'b1;
            repeat (12) @(negedge clk);
            if (use_osc) osc_in = 1'b0; else clk_pin = 1'b0;
            repeat (12) @(negedge clk);
        end
        if (use_osc) osc_in = 1'b1; else clk_pin = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic settle_low();
        clk_pin = 1'b0; osc_in = 1'b0;
        repeat (24) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_val(K_COUNT, 0, "R1 count after reset");
        expect_val(K_FLAG, 0, "R1 flag after reset");
        expect_val(K_OVF_SEEN, 0, "R1 no overflow pulse");

        // R2: internal tick, reset config is bypass
        wr_cnt(8'h10); wait_ticks(12);
        expect_val(K_COUNT, 8'h1A, "R2 one per four clocks");

        // R3: two-tick hold-off
        wr_cnt(8'h40); wait_ticks(2);
        expect_val(K_COUNT, 8'h40, "R3 held for two ticks");
        wr_cnt(8'h40); wait_ticks(3);
        expect_val(K_COUNT, 8'h41, "R3 counts on third tick");

        // R4: prescaler ratios
        wr_cfg(mk_cfg(0, 0, 0, 0, 0)); wr_cnt(8'h00); wait_ticks(12);
        expect_val(K_COUNT, 5, "R4 ratio 1:2");
        wr_cfg(mk_cfg(0, 0, 0, 0, 2)); wr_cnt(8'h00); wait_ticks(22);
        expect_val(K_COUNT, 2, "R4 ratio 1:8");
        wr_cfg(mk_cfg(0, 0, 0, 0, 7)); wr_cnt(8'h00); wait_ticks(602);
        expect_val(K_COUNT, 2, "R4 ratio 1:256");
        wr_cfg(mk_cfg(0, 0, 0, 1, 7)); wr_cnt(8'h00); wait_ticks(7);
        expect_val(K_COUNT, 5, "R4 bypass ignores ratio");

        // R5: load clears partial prescale
        wr_cfg(mk_cfg(0, 0, 0, 0, 1)); wr_cnt(8'h00); wait_ticks(5);
        expect_val(K_COUNT, 0, "R5 three of four events");
        wr_cnt(8'h00); wait_ticks(5);
        expect_val(K_COUNT, 0, "R5 prescaler restarted by load");

        // R6: wrap
        wr_cfg(mk_cfg(0, 0, 0, 1, 0)); wr_cnt(8'hFD); wait_ticks(5);
        expect_val(K_COUNT, 0, "R6 wrap to zero");
        expect_val(K_FLAG, 1, "R6 flag set");
        expect_val(K_OVF_SEEN, 1, "R6 single pulse");
        wait_ticks(3);
        expect_val(K_FLAG, 1, "R6 flag sticky");

        // R7: clear, then set wins over clear
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        expect_val(K_FLAG, 0, "R7 clear");
        expect_val(K_COUNT, 3, "R7 clear leaves count");
        irq_clr = 1'b1;
        wr_cnt(8'hFF); wait_ticks(4);
        expect_val(K_OVF_SEEN, 2, "R7 overflow under clear");
        expect_val(K_FLAG_AT_OVF, 1, "R7 set wins");
        expect_val(K_FLAG, 0, "R7 clear after overflow");
        irq_clr = 1'b0;

        // R8: polarity on the pin
        wr_cfg(mk_cfg(1, 0, 0, 1, 0)); wr_cnt(8'h00); settle_low();
        toggle_run(1'b0, 5);
        expect_val(K_COUNT, 6, "R8 rising edges");
        settle_low();
        wr_cfg(mk_cfg(1, 0, 1, 1, 0)); wr_cnt(8'h00); settle_low();
        toggle_run(1'b0, 5);
        expect_val(K_COUNT, 5, "R8 falling edges");
        settle_low();

        // R9: oscillator select, pin ignored
        wr_cfg(mk_cfg(1, 1, 0, 1, 0)); wr_cnt(8'h00); settle_low();
        toggle_run(1'b1, 3);
        expect_val(K_COUNT, 4, "R9 oscillator edges");
        toggle_run(1'b0, 3);
        expect_val(K_COUNT, 4, "R9 pin ignored");
        settle_low();

        // R10: latency and single count per transition
        wr_cfg(mk_cfg(1, 0, 0, 1, 0)); wr_cnt(8'h20); settle_low();
        clk_pin = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(K_COUNT, 8'h20, "R10 not yet counted");
        repeat (60) @(negedge clk);
        expect_val(K_COUNT, 8'h21, "R10 one count for held level");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule